// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit cipher key with the AES algorithm. It uses a single folded round datapath that is reused once per clock. A start strobe loads the plaintext and key. The initial key whitening happens on that same edge. The next ten edges then apply nine full rounds and one final round without column mixing. A step counter sequences the rounds and picks the full or the final round path. A key-step block runs in lockstep with the counter and supplies exactly one fresh round key per step. It needs no request or acknowledge.

The ciphertext appears on the same register that carries the working state, and a one-cycle done pulse marks it valid. The ciphertext then stays put until the next accepted start. All sixteen state bytes pass through their own substitution units in parallel, so each round costs one clock. A block therefore takes eleven clock edges from the start edge to the edge that raises done, counting both.

Top module: `aes128_iter_core`

## Requirements
- R1: A synchronous active-high reset clears the state and ciphertext register to zero, clears the step counter, and deasserts busy and done.
- R2: On the 128-bit buses, byte k occupies bits [127-8k:120-8k], so byte 0 is the most significant byte. Byte k holds state row k mod 4, column k div 4, which fills the state column by column.
- R3: A start seen while idle loads plaintext XOR cipher key into the state on that edge, raises busy and sets the step counter to 1.
- R4: Each of steps 1 to 9 applies byte substitution, then row rotation, then column mixing, then XOR with that step's round key.
- R5: Step 10 skips column mixing and XORs the rotated state with the tenth round key. The result is the ciphertext, and it matches the standard AES-128 vectors.
- R6: Row rotation moves row r left by r byte positions, for r from 0 to 3.
- R7: Byte substitution is the standard AES S-box, computed as the GF(2^8) inverse followed by the affine map with constant 0x63. Column mixing multiplies each column by the circulant matrix (2,3,1,1) modulo x^8+x^4+x^3+x+1.
- R8: The key step yields round key i from round key i-1 with the round constant 0x01 doubled in GF(2^8) at each step. One key is produced per step, with the cipher key reloaded on every accepted start.
- R9: The done output is high for exactly one cycle, in the cycle after step 10. It rises on the edge ten edges after the start edge, and busy falls on that same edge.
- R10: A start asserted while busy is ignored. It changes neither the running computation nor the number of done pulses.
- R11: While idle and without start, the ciphertext output holds its value.
- R12: A start presented in the same cycle that done is high is accepted, so blocks can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin encryption of pt_i under key_i when idle |
| key_i | input | 128 | Cipher key, byte 0 in the top bits |
| pt_i | input | 128 | Plaintext block, byte 0 in the top bits |
| busy_o | output | 1 | High while rounds are being applied |
| done_o | output | 1 | One-cycle pulse when ct_o holds a fresh ciphertext |
| ct_o | output | 128 | Ciphertext; shows intermediate state while busy |

## Verification
The hardest cases to reach from the ports are the ones where a new start collides with an ongoing run. One is a start that arrives mid-computation with different key and plaintext. The other is a start placed in the very cycle done is high. The stimulus issues a second strobe three cycles into a run and carries different data on it. The scoreboard then expects only the first block's ciphertext and no extra done pulse. Another run is chained by raising start on the same falling edge where done is observed, so the next block loads with no idle gap. Known-answer vectors cover the substitution, rotation, mixing and key-step paths together, because any error in any round changes the final ciphertext.

// File: rtl/aes128_iter_pkg.sv
package aes128_iter_pkg;

    localparam int BYTE_W     = 8;
    localparam int NB_BYTES   = 16;
    localparam int BLK_W      = BYTE_W * NB_BYTES;
    localparam int WORD_W     = 32;
    localparam int NUM_ROUNDS = 10;
    localparam int CNT_W      = $clog2(NUM_ROUNDS + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [CNT_W-1:0]  step_t;

    typedef enum logic {
        PASS_FULL = 1'b0,
        PASS_LAST = 1'b1
    } pass_kind_e;

    typedef struct packed {
        logic  busy;
        logic  done;
        step_t step;
    } seq_t;

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t m;
        acc = '0;
        m   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ m;
            m = xtime(m);
        end
        return acc;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    // Inverse by raising to the 254th power, then the affine map.
    function automatic byte_t sbox_fwd(input byte_t x);
        byte_t x2, x3, x12, x15, x240, inv;
        x2   = gf_mul(x, x);
        x3   = gf_mul(x2, x);
        x12  = gf_mul(gf_mul(x3, x3), gf_mul(x3, x3));
        x15  = gf_mul(x12, x3);
        x240 = gf_mul(x15, x15);
        x240 = gf_mul(x240, x240);
        x240 = gf_mul(x240, x240);
        x240 = gf_mul(x240, x240);
        inv  = gf_mul(gf_mul(x240, x12), x2);
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    function automatic byte_t blk_byte(input blk_t b, input int k);
        return b[BLK_W-1-BYTE_W*k -: BYTE_W];
    endfunction

endpackage

// File: rtl/aes128_sbox_byte.sv
module aes128_sbox_byte
    import aes128_iter_pkg::*;
(
    input  byte_t a_i,
    output byte_t y_o
);
    assign y_o = sbox_fwd(a_i);
endmodule

// File: rtl/aes128_round_unit.sv
module aes128_round_unit
    import aes128_iter_pkg::*;
(
    input  blk_t       state_i,
    input  blk_t       rkey_i,
    input  pass_kind_e kind_i,
    output blk_t       state_o
);
    localparam int ROWS = 4;
    localparam int COLS = NB_BYTES / ROWS;

    byte_t sub_b [NB_BYTES];
    byte_t shf_b [NB_BYTES];
    byte_t mix_b [NB_BYTES];

    for (genvar k = 0; k < NB_BYTES; k++) begin : g_sub
        aes128_sbox_byte u_sb (
            .a_i (state_i[BLK_W-1-BYTE_W*k -: BYTE_W]),
            .y_o (sub_b[k])
        );
    end

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                shf_b[ROWS*c + r] = sub_b[ROWS*((c + r) % COLS) + r];
            end
        end
    end

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            byte_t s0, s1, s2, s3;
            s0 = shf_b[ROWS*c];
            s1 = shf_b[ROWS*c + 1];
            s2 = shf_b[ROWS*c + 2];
            s3 = shf_b[ROWS*c + 3];
            mix_b[ROWS*c]     = xtime(s0) ^ (xtime(s1) ^ s1) ^ s2 ^ s3;
            mix_b[ROWS*c + 1] = s0 ^ xtime(s1) ^ (xtime(s2) ^ s2) ^ s3;
            mix_b[ROWS*c + 2] = s0 ^ s1 ^ xtime(s2) ^ (xtime(s3) ^ s3);
            mix_b[ROWS*c + 3] = (xtime(s0) ^ s0) ^ s1 ^ s2 ^ xtime(s3);
        end
    end

    always_comb begin
        for (int k = 0; k < NB_BYTES; k++) begin
            state_o[BLK_W-1-BYTE_W*k -: BYTE_W] =
                ((kind_i == PASS_LAST) ? shf_b[k] : mix_b[k]) ^ blk_byte(rkey_i, k);
        end
    end
endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step
    import aes128_iter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  blk_t key_i,
    input  logic adv_i,
    output blk_t rkey_o
);
    localparam int NWORDS = BLK_W / WORD_W;

    blk_t  kreg_q;
    byte_t rcon_q;
    word_t rot_w;
    word_t sub_w;
    word_t nxt_w [NWORDS];

    assign rot_w = {kreg_q[WORD_W-9:0], kreg_q[WORD_W-1 -: BYTE_W]};

    for (genvar j = 0; j < WORD_W / BYTE_W; j++) begin : g_ksb
        aes128_sbox_byte u_sb (
            .a_i (rot_w[WORD_W-1-BYTE_W*j -: BYTE_W]),
            .y_o (sub_w[WORD_W-1-BYTE_W*j -: BYTE_W])
        );
    end

    always_comb begin
        word_t prev;
        prev = sub_w ^ {rcon_q, {(WORD_W-BYTE_W){1'b0}}};
        for (int w = 0; w < NWORDS; w++) begin
            nxt_w[w] = kreg_q[BLK_W-1-WORD_W*w -: WORD_W] ^ prev;
            prev     = nxt_w[w];
            rkey_o[BLK_W-1-WORD_W*w -: WORD_W] = nxt_w[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kreg_q <= '0;
            rcon_q <= 8'h01;
        end else if (load_i) begin
            kreg_q <= key_i;
            rcon_q <= 8'h01;
        end else if (adv_i) begin
            kreg_q <= rkey_o;
            rcon_q <= xtime(rcon_q);
        end
    end
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
    import aes128_iter_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [127:0] key_i,
    input  logic [127:0] pt_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [127:0] ct_o
);
    localparam step_t LAST_STEP = step_t'(NUM_ROUNDS);

    seq_t       seq_q;
    blk_t       state_q;
    blk_t       rkey;
    blk_t       round_out;
    pass_kind_e kind;
    logic       accept;
    logic       busy_q;
    step_t      step_q;

    assign busy_q = seq_q.busy;
    assign step_q = seq_q.step;
    assign accept = start_i && !seq_q.busy;
    assign kind   = (seq_q.step == LAST_STEP) ? PASS_LAST : PASS_FULL;

    aes128_key_step u_key (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .key_i  (key_i),
        .adv_i  (seq_q.busy),
        .rkey_o (rkey)
    );

    aes128_round_unit u_round (
        .state_i (state_q),
        .rkey_i  (rkey),
        .kind_i  (kind),
        .state_o (round_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            seq_q   <= '0;
        end else begin
            seq_q.done <= 1'b0;
            if (accept) begin
                state_q    <= pt_i ^ key_i;
                seq_q.busy <= 1'b1;
                seq_q.step <= step_t'(1);
            end else if (seq_q.busy) begin
                state_q <= round_out;
                if (seq_q.step == LAST_STEP) begin
                    seq_q.busy <= 1'b0;
                    seq_q.done <= 1'b1;
                    seq_q.step <= '0;
                end else begin
                    seq_q.step <= seq_q.step + step_t'(1);
                end
            end
        end
    end

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;
    assign ct_o   = state_q;
endmodule

// File: rtl/aes128_iter_core_chk.sv
module aes128_iter_core_chk
    import aes128_iter_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         busy,
    input logic         done,
    input step_t        step,
    input logic [127:0] ct
);
    // R1
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step <= step_t'(NUM_ROUNDS));

    // R3
    load_step_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy) |=> (busy && step == step_t'(1)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && $past(step) == step_t'(NUM_ROUNDS) && !busy));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i && step < step_t'(NUM_ROUNDS)) |=> (busy && step == $past(step) + step_t'(1)));

    // R11
    ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> $stable(ct));
endmodule

bind aes128_iter_core aes128_iter_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy    (busy_q),
    .done    (done_o),
    .step    (step_q),
    .ct      (ct_o)
);

// File: tb/aes128_iter_core_bench.sv
module aes128_iter_core_bench;

    typedef struct {
        logic [127:0] exp;
        int           t0;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] pt_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] ct_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    int    pushed   = 0;
    int    popped   = 0;
    bit    finished = 1'b0;
    item_t sb_q[$];

    localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] C3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    aes128_iter_core u_aes128_iter_core (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .key_i   (key_i),
        .pt_i    (pt_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .ct_o    (ct_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Driver: called at a falling edge; raises start for one cycle and queues the expectation.
    task automatic drive_block(input logic [127:0] k, input logic [127:0] p,
                               input logic [127:0] exp);
        item_t it;
        key_i   = k;
        pt_i    = p;
        start_i = 1'b1;
        it.exp  = exp;
        it.t0   = cyc;
        sb_q.push_back(it);
        pushed++;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Monitor: pops the scoreboard at each done pulse.
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected done pulse", 128'd1, 128'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                popped++;
                // R2 R3 R4 R5 R6 R7 R8: ciphertext against known answer
                check(ct_o === it.exp, "R5 ciphertext (R2 R4 R6 R7 R8)", ct_o, it.exp);
                // R9: start edge to done edge spans 11 edges counted from the driving negedge
                check((cyc - it.t0) == 11, "R9 latency", 128'(cyc - it.t0), 128'd11);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 128'd0, 128'd1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(ct_o === '0, "R1 ct after reset", ct_o, '0);
        check(done_o === 1'b0, "R1 done after reset", 128'(done_o), 128'd0);
        check(busy_o === 1'b0, "R1 busy after reset", 128'(busy_o), 128'd0);

        drive_block(K1, P1, C1);
        wait_done();
        @(negedge clk);
        check(done_o === 1'b0, "R9 done width", 128'(done_o), 128'd0);
        repeat (5) @(negedge clk);
        // R11
        check(ct_o === C1, "R11 ct held while idle", ct_o, C1);

        drive_block(K2, P2, C2);
        repeat (2) @(negedge clk);
        // R10: strobe with other data while busy; not queued
        key_i   = '0;
        pt_i    = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        // R12: start in the same cycle done is high
        drive_block('0, '0, C3);
        wait_done();
        @(negedge clk);
        drive_block(K1, P1, C1);
        wait_done();
        repeat (15) @(negedge clk);
        // R10
        check(busy_o === 1'b0, "R10 idle after ignored start", 128'(busy_o), 128'd0);
        check(popped == pushed, "R10 done count", 128'(popped), 128'(pushed));
        check(ct_o === C1, "R11 ct held at end", ct_o, C1);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule